// File: doc/BRIEF.md
# Sliding-Window Packet Accumulator

This block turns a stream of per-packet quality verdicts into a slow, debounced tone indication. A tone qualifier upstream issues a one-cycle strobe at the end of every packet, together with a flag that says whether that packet carried a good tone. The accumulator keeps the most recent verdicts in a shift history and tracks how many of them are good inside a window whose length depends on the selected tone system.

The active-low output goes to "present" once the good packets in the window reach a threshold. It goes back to "absent" once the bad packets in the window reach the same threshold. Between those two points it holds, so short fades in a tone and short bursts of noise both leave it unchanged. With qualifying packets arriving back to back, either change takes exactly threshold packets, which is 40 ms in either system. The window spans 48 ms.

Changing the system select wipes the history and forces the output to "absent", so that verdicts taken under one packet length never mix with verdicts taken under the other.

Top module: `pkt_window_det`

## Requirements
- R1: During and right after synchronous active-low reset, `tone_n_o` is 1 (tone absent) and every history entry counts as a bad packet.
- R2: With `sys_sel_i` = 0 (16 kHz system), the window holds 24 packets and the output goes to 0 once 20 of them are good; after reset, 20 consecutive good strobes give 0 and 19 give 1.
- R3: With `sys_sel_i` = 1 (12 kHz system), the window holds 18 packets and the threshold is 15; after reset, 15 consecutive good strobes give 0 and 14 give 1.
- R4: The output goes to 1 once the bad packets in the window (window length minus good count) reach the threshold; from a solid tone this takes threshold consecutive bad strobes.
- R5: While neither count reaches the threshold, the output keeps its last value, so a short break in a tone or a short burst in silence does not change it.
- R6: Good packets need not be consecutive: in the 16 kHz system, 10 good, 2 bad and 10 good strobes give 0 on the 22nd strobe and 1 on the 21st.
- R7: A packet older than the window length no longer counts: after reset in the 16 kHz system, 19 good, 5 bad and 1 good strobe leave the output at 1.
- R8: A clock cycle in which `sys_sel_i` differs from its value in the previous cycle clears the history to all bad and sets the output to 1; a strobe in that same cycle is dropped.
- R9: Without a strobe, `pkt_good_i` has no effect and the output does not change.
- R10: The output reflects a strobe on the clock edge that samples that strobe, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| sys_sel_i | input | 1 | System select: 1 = 12 kHz system, 0 = 16 kHz system |
| pkt_stb_i | input | 1 | One-cycle strobe at the end of each packet |
| pkt_good_i | input | 1 | Verdict for the strobed packet: 1 = good tone, 0 = bad or no tone |
| tone_n_o | output | 1 | Packet-mode tone indication: 0 = tone present, 1 = tone absent |

## Verification
The assertions take for granted that each threshold is more than half its window and no larger than it, so the two switching conditions can never hold at once, and that the packet strobe is a single-cycle pulse. They also assume that the system select moves only as a deliberate step between otherwise quiet cycles. The bench drives every strobe for exactly one cycle with an idle cycle after it, and changes the system select only at chosen points, once together with a strobe to show that this strobe is dropped. Expected outputs come from hand-counted packet sequences, so each check names the strobe count at which the window crosses its threshold.

// File: rtl/pkt_win_pkg.sv
package pkt_win_pkg;

    // Level on the active-low tone output
    typedef enum logic {
        TONE_PRESENT = 1'b0,
        TONE_ABSENT  = 1'b1
    } tone_lvl_e;

    // System select encoding
    typedef enum logic {
        SYS_16K = 1'b0,
        SYS_12K = 1'b1
    } sys_mode_e;

    // Default history depth (the longer of the two windows)
    localparam int unsigned HIST_DEPTH_DEF = 24;

endpackage

// File: rtl/pkt_cfg_sel.sv
module pkt_cfg_sel #(
    parameter int unsigned WIN_12K = 18,
    parameter int unsigned THR_12K = 15,
    parameter int unsigned WIN_16K = 24,
    parameter int unsigned THR_16K = 20,
    parameter int unsigned LEN_W   = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sys_sel_i,
    output logic             sys_chg_o,
    output logic [LEN_W-1:0] win_len_o,
    output logic [LEN_W-1:0] thr_o
);
    import pkt_win_pkg::*;

    typedef struct packed {
        sys_mode_e sys;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d     = cfg_q;
        cfg_d.sys = sys_mode_e'(sys_sel_i);
        sys_chg_o = (sys_mode_e'(sys_sel_i) != cfg_q.sys);
        if (cfg_q.sys == SYS_12K) begin
            win_len_o = LEN_W'(WIN_12K);
            thr_o     = LEN_W'(THR_12K);
        end else begin
            win_len_o = LEN_W'(WIN_16K);
            thr_o     = LEN_W'(THR_16K);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q.sys <= sys_mode_e'(sys_sel_i);
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/pkt_hist_shift.sv
module pkt_hist_shift #(
    parameter int unsigned HIST_MAX = 24,
    parameter int unsigned LEN_W    = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             shift_i,
    input  logic             bit_i,
    input  logic [LEN_W-1:0] win_len_i,
    output logic             leave_o
);
    localparam int unsigned IDX_W = (HIST_MAX > 1) ? $clog2(HIST_MAX) : 1;

    typedef struct packed {
        logic [HIST_MAX-1:0] bits;
    } hist_state_t;

    hist_state_t hist_d, hist_q;
    logic [IDX_W-1:0] oldest_idx;

    always_comb begin
        hist_d     = hist_q;
        oldest_idx = IDX_W'(win_len_i - LEN_W'(1));
        leave_o    = (win_len_i != '0) ? hist_q.bits[oldest_idx] : 1'b0;
        if (clr_i) begin
            hist_d.bits = '0;
        end else if (shift_i) begin
            hist_d.bits = {hist_q.bits[HIST_MAX-2:0], bit_i};
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

endmodule

// File: rtl/pkt_good_count.sv
module pkt_good_count #(
    parameter int unsigned LEN_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             step_i,
    input  logic             bit_i,
    input  logic             leave_i,
    output logic [LEN_W-1:0] cnt_o,
    output logic [LEN_W-1:0] cnt_next_o
);
    typedef struct packed {
        logic [LEN_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d.cnt = '0;
        end else if (step_i) begin
            cnt_d.cnt = cnt_q.cnt + LEN_W'(bit_i) - LEN_W'(leave_i);
        end
        cnt_o      = cnt_q.cnt;
        cnt_next_o = cnt_d.cnt;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/pkt_hyst_decide.sv
module pkt_hyst_decide #(
    parameter int unsigned LEN_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             eval_i,
    input  logic [LEN_W-1:0] cnt_next_i,
    input  logic [LEN_W-1:0] win_len_i,
    input  logic [LEN_W-1:0] thr_i,
    output logic             tone_n_o
);
    import pkt_win_pkg::*;

    typedef struct packed {
        tone_lvl_e lvl;
    } dec_state_t;

    dec_state_t dec_d, dec_q;
    logic [LEN_W-1:0] bad_next;

    always_comb begin
        dec_d    = dec_q;
        bad_next = win_len_i - cnt_next_i;
        if (clr_i) begin
            dec_d.lvl = TONE_ABSENT;
        end else if (eval_i) begin
            if (cnt_next_i >= thr_i) begin
                dec_d.lvl = TONE_PRESENT;
            end else if (bad_next >= thr_i) begin
                dec_d.lvl = TONE_ABSENT;
            end
        end
        tone_n_o = dec_q.lvl;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dec_q.lvl <= TONE_ABSENT;
        end else begin
            dec_q <= dec_d;
        end
    end

endmodule

// File: rtl/pkt_window_det.sv
module pkt_window_det #(
    parameter int unsigned HIST_MAX = pkt_win_pkg::HIST_DEPTH_DEF,
    parameter int unsigned WIN_12K  = 18,
    parameter int unsigned THR_12K  = 15,
    parameter int unsigned WIN_16K  = 24,
    parameter int unsigned THR_16K  = 20
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sys_sel_i,
    input  logic pkt_stb_i,
    input  logic pkt_good_i,
    output logic tone_n_o
);
    localparam int unsigned LEN_W = $clog2(HIST_MAX + 1);

    logic             sys_chg;
    logic [LEN_W-1:0] win_len;
    logic [LEN_W-1:0] thr;
    logic             stb_eff;
    logic             leave_bit;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] cnt_next;

    // A strobe coinciding with a system change is dropped
    assign stb_eff = pkt_stb_i && !sys_chg;

    pkt_cfg_sel #(
        .WIN_12K (WIN_12K),
        .THR_12K (THR_12K),
        .WIN_16K (WIN_16K),
        .THR_16K (THR_16K),
        .LEN_W   (LEN_W)
    ) u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sys_sel_i (sys_sel_i),
        .sys_chg_o (sys_chg),
        .win_len_o (win_len),
        .thr_o     (thr)
    );

    pkt_hist_shift #(
        .HIST_MAX (HIST_MAX),
        .LEN_W    (LEN_W)
    ) u_hist (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (sys_chg),
        .shift_i   (stb_eff),
        .bit_i     (pkt_good_i),
        .win_len_i (win_len),
        .leave_o   (leave_bit)
    );

    pkt_good_count #(
        .LEN_W (LEN_W)
    ) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (sys_chg),
        .step_i     (stb_eff),
        .bit_i      (pkt_good_i),
        .leave_i    (leave_bit),
        .cnt_o      (cnt_q),
        .cnt_next_o (cnt_next)
    );

    pkt_hyst_decide #(
        .LEN_W (LEN_W)
    ) u_dec (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (sys_chg),
        .eval_i     (stb_eff),
        .cnt_next_i (cnt_next),
        .win_len_i  (win_len),
        .thr_i      (thr),
        .tone_n_o   (tone_n_o)
    );

endmodule

// File: rtl/pkt_window_det_chk.sv
module pkt_window_det_chk #(
    parameter int unsigned LEN_W = 5
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             pkt_stb_i,
    input logic             sys_chg,
    input logic [LEN_W-1:0] cnt_q,
    input logic [LEN_W-1:0] win_len,
    input logic [LEN_W-1:0] thr,
    input logic             tone_n_o
);

    AST_CNT_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= win_len); // R7

    AST_DETECT_AT_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(tone_n_o) |-> (cnt_q >= thr)); // R2

    AST_RELEASE_AT_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tone_n_o) |-> ((win_len - cnt_q) >= thr)); // R4

    AST_SYS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_chg |=> (tone_n_o && (cnt_q == '0))); // R8

    AST_OUT_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pkt_stb_i && !sys_chg) |=> $stable(tone_n_o)); // R9

    AST_CNT_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pkt_stb_i && !sys_chg) |=> $stable(cnt_q)); // R9

    AST_CNT_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pkt_stb_i && !sys_chg) |=>
            ((cnt_q <= $past(cnt_q) + LEN_W'(1)) && (cnt_q + LEN_W'(1) >= $past(cnt_q)))); // R6

endmodule

bind pkt_window_det pkt_window_det_chk #(.LEN_W(LEN_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pkt_stb_i (pkt_stb_i),
    .sys_chg   (sys_chg),
    .cnt_q     (cnt_q),
    .win_len   (win_len),
    .thr       (thr),
    .tone_n_o  (tone_n_o)
);

// File: tb/test_pkt_window_det.sv
module test_pkt_window_det;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_sel = 1'b1;
    logic stb = 1'b0;
    logic good = 1'b0;
    logic tone_n;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pkt_window_det i_pkt_window_det (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .sys_sel_i  (sys_sel),
        .pkt_stb_i  (stb),
        .pkt_good_i (good),
        .tone_n_o   (tone_n)
    );

    // Vector: {sys_sel, good verdict, expected tone_n after the strobe}
    // 12 kHz system from reset: 14 good hold, 15th detects (R3);
    // 14 bad hold (R5), 15th releases (R4); 3 good stay absent (R5).
    localparam logic [2:0] VEC [33] = '{
        3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111,
        3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111,
        3'b110,
        3'b100, 3'b100, 3'b100, 3'b100, 3'b100, 3'b100, 3'b100,
        3'b100, 3'b100, 3'b100, 3'b100, 3'b100, 3'b100, 3'b100,
        3'b101,
        3'b111, 3'b111, 3'b111
    };

    task automatic check(input logic exp, input string tag);
        n_checks++;
        if (tone_n !== exp) begin
            n_fail++;
            $display("FAIL %s: tone_n actual %b expected %b", tag, tone_n, exp);
        end
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst_n = 1'b0;
        sys_sel = s;
        stb = 1'b0;
        good = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One-cycle strobe; output sampled at the next falling edge (R10)
    task automatic strobe(input logic g);
        @(negedge clk);
        stb = 1'b1;
        good = g;
        @(negedge clk);
        stb = 1'b0;
        good = 1'b0;
    endtask

    task automatic strobes(input logic g, input int n);
        for (int i = 0; i < n; i++) strobe(g);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        do_reset(1'b1);
        check(1'b1, "R1 reset output");

        // Table walk in the 12 kHz system
        for (int v = 0; v < 33; v++) begin
            sys_sel = VEC[v][2];
            strobe(VEC[v][1]);
            check(VEC[v][0], $sformatf("R3/R4/R5 vector %0d", v));
        end

        // R1: history starts all bad, 19 goods in 16 kHz do not detect
        do_reset(1'b0);
        check(1'b1, "R1 reset output 16k");
        strobes(1'b1, 19);
        check(1'b1, "R1 19 good after reset");
        // R7: oldest good leaves the 24-entry window
        strobes(1'b0, 5);
        check(1'b1, "R7 after 5 bad");
        strobe(1'b1);
        check(1'b1, "R7 aged packet not counted");

        // R6: non-consecutive goods accumulate
        do_reset(1'b0);
        strobes(1'b1, 10);
        strobes(1'b0, 2);
        strobes(1'b1, 9);
        check(1'b1, "R6 19 good in window");
        strobe(1'b1);
        check(1'b0, "R6 20 good in window");

        // R8: system change clears, coincident strobe dropped
        do_reset(1'b1);
        strobes(1'b1, 15);
        check(1'b0, "R3 15 good detect");
        @(negedge clk);
        sys_sel = 1'b0;
        stb = 1'b1;
        good = 1'b1;
        @(negedge clk);
        stb = 1'b0;
        good = 1'b0;
        check(1'b1, "R8 output forced absent");
        strobes(1'b1, 19);
        check(1'b1, "R8 history cleared, strobe dropped");
        strobe(1'b1);
        check(1'b0, "R2 20 good detect");

        // R9: verdict without strobe is ignored
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            good = i[0];
            @(negedge clk);
            check(1'b0, "R9 no strobe no change");
        end
        good = 1'b0;

        // R4: release in the 16 kHz system after 20 bad
        strobes(1'b0, 19);
        check(1'b0, "R4 19 bad hold");
        strobe(1'b0);
        check(1'b1, "R4 20 bad release");

        // R10: output visible on the edge sampling the strobe
        strobes(1'b1, 19);
        @(negedge clk);
        stb = 1'b1;
        good = 1'b1;
        check(1'b1, "R10 before edge");
        @(posedge clk);
        #1;
        stb = 1'b0;
        good = 1'b0;
        check(1'b0, "R10 after edge");

        finish_run();
    end

endmodule